// File: doc/BRIEF.md
# Reset and Processor-Mode Controller

This block turns an active-low external reset pin and a self-clearing software-reset bit into one internal reset for the rest of the chip. A low level on the pin counts only after it has lasted a fixed number of clock cycles, so short glitches cannot reset the chip. The block also holds two processor-mode configuration registers behind a write-guard register. A level on a start-mode pin sets what those registers hold after any reset. Once reset is released, the block issues the short run of reset-vector fetch requests that start execution.

The configuration registers drive the outputs that the rest of the chip uses:
- the current processor mode;
- the address-area mode;
- an internal-memory wait selection;
- which pin, if any, carries the address-latch strobe.

A byte-wide register port writes the registers, and a read port returns their stored contents. The memory read behind each vector request, and any oscillator settling, belong to other blocks.

Top module: `boot_mode_ctrl`

## Requirements
- R1: The internal reset asserts only after the two-flop-synchronised pin has been sampled low on 20 consecutive clock edges. Any high sample before then restarts the count, so a low pulse of 19 cycles never resets the chip.
- R2: Once recognised, the hardware reset stays asserted while the pin stays low. It releases after the pin returns high.
- R3: On reset, register 0 (address 0) loads 0x80 when the start-mode pin is low and 0x03 when it is high. Register 1 (address 1) and the guard register (address 2) load 0x00.
- R4: An accepted write to register 0 with bit 3 set asserts the internal reset for 4 cycles. That reset restores every register to its R3 value. Bit 3 is never stored and always reads 0.
- R5: Writes to registers 0 and 1 are ignored unless guard-register bit 1 is 1. This also applies to the software-reset bit. The guard register is always writable, keeps only bit 1, and reads back as 0x00 or 0x02.
- R6: Register 0 bits 1:0 are the processor mode, driven on `pmode_o`:
  - 00 is single-chip.
  - 01 is memory expansion.
  - 11 is microprocessor.
  - A written value of 10 leaves the previous mode in place, while the other written bits still update.
- R7: Register 1 keeps only bits 5:4 and 2:0 and reads 0 elsewhere:
  - Bits 1:0 drive `area_o`.
  - Bit 2 drives `mem_wait_o`.
  - Bits 5:4 drive `strobe_sel_o`: 00 none, 01 bus-clock pin, 10 row-strobe pin, 11 hold-acknowledge pin.
- R8: In the first cycle after the internal reset falls, the block asserts `vec_req_o` for consecutive cycles and then drops it:
  - With a 16-bit bus (`bus8_sel` low, sampled during reset), the addresses are 0xFFFFFC and then 0xFFFFFE.
  - With an 8-bit bus, the addresses are 0xFFFFFC, 0xFFFFFD and then 0xFFFFFE.
- R9: Register address 3 is unused. Writes to it have no effect and it reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| mode_pin | input | 1 | Start-mode select: low single-chip, high microprocessor |
| bus8_sel | input | 1 | High when the external bus is 8 bits wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| rst_o | output | 1 | Internal reset, active high |
| pmode_o | output | 2 | Current processor mode |
| area_o | output | 2 | Address-area mode |
| mem_wait_o | output | 1 | Internal-memory wait insert |
| strobe_sel_o | output | 2 | Address-latch strobe pin selection |
| vec_req_o | output | 1 | Reset-vector fetch request |
| vec_addr_o | output | 24 | Reset-vector fetch address |

## Verification
Some properties are checked in the RTL on every cycle:
- The hardware reset never rises before the low count reaches its limit.
- A high synchronised pin always clears it.
- The mode field never holds the forbidden code.
- A locked write never changes a configuration register.
- An accepted software-reset write always raises the reset.
- Every vector sequence starts at the base address and stays halfword-aligned on a 16-bit bus.

Other behaviour can only be shown by the bench's scenarios:
- The exact 19-versus-20 cycle boundary.
- The reset values under both start-mode pin levels.
- The full address order of each vector sequence.
- The masking seen at the read port across all register-1 codes.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

    typedef enum logic [1:0] {
        PM_SINGLE = 2'b00,
        PM_EXPAND = 2'b01,
        PM_RSVD   = 2'b10,
        PM_MICRO  = 2'b11
    } pmode_e;

    localparam int REG_W = 8;

    localparam logic [1:0] RA_CFG0  = 2'd0;
    localparam logic [1:0] RA_CFG1  = 2'd1;
    localparam logic [1:0] RA_GUARD = 2'd2;

    localparam logic [REG_W-1:0] CFG0_RST_SINGLE = 8'h80;
    localparam logic [REG_W-1:0] CFG0_RST_MICRO  = 8'h03;
    localparam logic [REG_W-1:0] CFG1_KEEP       = 8'h37;
    localparam logic [REG_W-1:0] GUARD_KEEP      = 8'h02;

    localparam int SWRST_BIT = 3;
    localparam int UNLOCK_BIT = 1;

endpackage

// File: rtl/bmc_reset_filter.sv
module bmc_reset_filter #(
    parameter int LOW_CYCLES = 20,
    parameter int SW_PULSE   = 4
) (
    input  logic clk,
    input  logic pin_n,
    input  logic sw_req,
    output logic rst_o
);
    localparam int CNT_W = $clog2(LOW_CYCLES);
    localparam int SW_W  = $clog2(SW_PULSE + 1);
    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(LOW_CYCLES - 1);
    localparam logic [SW_W-1:0]  SW_START = SW_W'(SW_PULSE);

    typedef struct packed {
        logic [1:0]       sync;
        logic [CNT_W-1:0] cnt;
        logic             hold;
        logic [SW_W-1:0]  swcnt;
    } flt_t;

    flt_t flt_d, flt_q;
    logic pin_s;

    assign pin_s = flt_q.sync[1];

    always_comb begin
        flt_d      = flt_q;
        flt_d.sync = {flt_q.sync[0], pin_n};
        if (pin_s) begin
            flt_d.cnt  = '0;
            flt_d.hold = 1'b0;
        end else begin
            if (flt_q.cnt != CNT_TOP) begin
                flt_d.cnt = flt_q.cnt + 1'b1;
            end
            if (flt_q.cnt == CNT_TOP) begin
                flt_d.hold = 1'b1;
            end
        end
        if (flt_q.hold) begin
            flt_d.swcnt = '0;
        end else if (sw_req) begin
            flt_d.swcnt = SW_START;
        end else if (flt_q.swcnt != '0) begin
            flt_d.swcnt = flt_q.swcnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        flt_q <= flt_d;
    end

    assign rst_o = flt_q.hold | (flt_q.swcnt != '0);

    AST_NO_EARLY_RESET: assert property (@(posedge clk)
        $rose(flt_q.hold) |-> ($past(flt_q.cnt) == CNT_TOP)); // R1

    AST_HIGH_RELEASES: assert property (@(posedge clk)
        pin_s |=> !flt_q.hold); // R2

endmodule

// File: rtl/bmc_mode_regs.sv
module bmc_mode_regs
    import bmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_i,
    input  logic             start_micro,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [REG_W-1:0] rd_data,
    output logic             sw_req,
    output logic [1:0]       pmode,
    output logic [1:0]       area,
    output logic             mem_wait,
    output logic [1:0]       strobe_sel
);
    typedef struct packed {
        logic [REG_W-1:0] cfg0;
        logic [REG_W-1:0] cfg1;
        logic [REG_W-1:0] guard;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  unlocked;

    assign unlocked = regs_q.guard[UNLOCK_BIT];

    always_comb begin
        regs_d = regs_q;
        sw_req = 1'b0;
        if (rst_i) begin
            regs_d.cfg0  = start_micro ? CFG0_RST_MICRO : CFG0_RST_SINGLE;
            regs_d.cfg1  = '0;
            regs_d.guard = '0;
        end else if (wr_en) begin
            case (wr_addr)
                RA_GUARD: regs_d.guard = wr_data & GUARD_KEEP;
                RA_CFG0: begin
                    if (unlocked) begin
                        regs_d.cfg0            = wr_data;
                        regs_d.cfg0[SWRST_BIT] = 1'b0;
                        if (wr_data[1:0] == PM_RSVD) begin
                            regs_d.cfg0[1:0] = regs_q.cfg0[1:0];
                        end
                        sw_req = wr_data[SWRST_BIT];
                    end
                end
                RA_CFG1: begin
                    if (unlocked) begin
                        regs_d.cfg1 = wr_data & CFG1_KEEP;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    always_comb begin
        case (rd_addr)
            RA_CFG0:  rd_data = regs_q.cfg0;
            RA_CFG1:  rd_data = regs_q.cfg1;
            RA_GUARD: rd_data = regs_q.guard;
            default:  rd_data = '0;
        endcase
    end

    assign pmode      = regs_q.cfg0[1:0];
    assign area       = regs_q.cfg1[1:0];
    assign mem_wait   = regs_q.cfg1[2];
    assign strobe_sel = regs_q.cfg1[5:4];

    AST_MODE_NOT_RSVD: assert property (@(posedge clk) disable iff (rst_i)
        pmode != PM_RSVD); // R6

    AST_LOCKED_STABLE: assert property (@(posedge clk) disable iff (rst_i)
        (wr_en && !unlocked && wr_addr != RA_GUARD)
        |=> ($stable(regs_q.cfg0) && $stable(regs_q.cfg1))); // R5

endmodule

// File: rtl/bmc_vector_seq.sv
module bmc_vector_seq #(
    parameter int          ADDR_W   = 24,
    parameter logic [ADDR_W-1:0] VEC_BASE = 24'hFFFFFC
) (
    input  logic              clk,
    input  logic              rst_i,
    input  logic              bus8_i,
    output logic              req_o,
    output logic [ADDR_W-1:0] addr_o
);
    typedef struct packed {
        logic       active;
        logic [1:0] idx;
        logic       bus8;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [1:0] last_idx;
    logic [2:0] offset;

    assign last_idx = seq_q.bus8 ? 2'd2 : 2'd1;

    always_comb begin
        seq_d = seq_q;
        if (rst_i) begin
            seq_d.active = 1'b1;
            seq_d.idx    = '0;
            seq_d.bus8   = bus8_i;
        end else if (seq_q.active) begin
            if (seq_q.idx == last_idx) begin
                seq_d.active = 1'b0;
            end else begin
                seq_d.idx = seq_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        seq_q <= seq_d;
    end

    assign offset = seq_q.bus8 ? {1'b0, seq_q.idx} : {seq_q.idx, 1'b0};
    assign req_o  = seq_q.active & ~rst_i;
    assign addr_o = VEC_BASE + ADDR_W'(offset);

    AST_VEC_START: assert property (@(posedge clk)
        $fell(rst_i) |-> (req_o && addr_o == VEC_BASE)); // R8

    AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (rst_i)
        (req_o && !seq_q.bus8) |-> !addr_o[0]); // R8

endmodule

// File: rtl/boot_mode_ctrl.sv
module boot_mode_ctrl
    import bmc_pkg::*;
#(
    parameter int LOW_CYCLES = 20,
    parameter int SW_PULSE   = 4,
    parameter int ADDR_W     = 24,
    parameter logic [ADDR_W-1:0] VEC_BASE = 24'hFFFFFC
) (
    input  logic              clk,
    input  logic              ext_rst_n,
    input  logic              mode_pin,
    input  logic              bus8_sel,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [1:0]        rd_addr,
    output logic [7:0]        rd_data,
    output logic              rst_o,
    output logic [1:0]        pmode_o,
    output logic [1:0]        area_o,
    output logic              mem_wait_o,
    output logic [1:0]        strobe_sel_o,
    output logic              vec_req_o,
    output logic [ADDR_W-1:0] vec_addr_o
);
    logic sw_req;

    bmc_reset_filter #(
        .LOW_CYCLES (LOW_CYCLES),
        .SW_PULSE   (SW_PULSE)
    ) u_filter (
        .clk    (clk),
        .pin_n  (ext_rst_n),
        .sw_req (sw_req),
        .rst_o  (rst_o)
    );

    bmc_mode_regs u_regs (
        .clk         (clk),
        .rst_i       (rst_o),
        .start_micro (mode_pin),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .sw_req      (sw_req),
        .pmode       (pmode_o),
        .area        (area_o),
        .mem_wait    (mem_wait_o),
        .strobe_sel  (strobe_sel_o)
    );

    bmc_vector_seq #(
        .ADDR_W   (ADDR_W),
        .VEC_BASE (VEC_BASE)
    ) u_vec (
        .clk    (clk),
        .rst_i  (rst_o),
        .bus8_i (bus8_sel),
        .req_o  (vec_req_o),
        .addr_o (vec_addr_o)
    );

    AST_SW_RESET_TAKES: assert property (@(posedge clk)
        sw_req |=> rst_o); // R4

endmodule

// File: tb/boot_mode_ctrl_bench.sv
module boot_mode_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        ext_rst_n, mode_pin, bus8_sel, wr_en;
    logic [1:0]  wr_addr, rd_addr;
    logic [7:0]  wr_data, rd_data;
    logic        rst_o, mem_wait_o, vec_req_o;
    logic [1:0]  pmode_o, area_o, strobe_sel_o;
    logic [23:0] vec_addr_o;

    int n_chk = 0;
    int n_fail = 0;

    boot_mode_ctrl u_boot_mode_ctrl (
        .clk(clk), .ext_rst_n(ext_rst_n), .mode_pin(mode_pin), .bus8_sel(bus8_sel),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .rst_o(rst_o), .pmode_o(pmode_o), .area_o(area_o),
        .mem_wait_o(mem_wait_o), .strobe_sel_o(strobe_sel_o),
        .vec_req_o(vec_req_o), .vec_addr_o(vec_addr_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Called while rst_o is high; follows the vector run after release.
    task automatic vec_seq(input string tag, input logic b8);
        int n = b8 ? 3 : 2;
        while (rst_o) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            chk(tag, {7'd0, vec_req_o, vec_addr_o},
                {7'd0, 1'b1, 24'hFFFFFC + 24'(b8 ? k : 2 * k)});
            @(negedge clk);
        end
        chk(tag, {31'd0, vec_req_o}, 32'd0);
    endtask

    task automatic hw_reset(input int low_len);
        ext_rst_n = 1'b0;
        repeat (low_len) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic [1:0] prev_mode, exp_mode;
        logic saw;
        ext_rst_n = 1'b1; mode_pin = 1'b0; bus8_sel = 1'b0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (4) @(negedge clk);

        // R2 / R3: long low with single-chip start
        hw_reset(25);
        chk("R2 reset held while pin low", {31'd0, rst_o}, 32'd1);
        rd(2'd0, v); chk("R3 cfg0 reset single", {24'd0, v}, 32'h80);
        rd(2'd1, v); chk("R3 cfg1 reset", {24'd0, v}, 32'h00);
        rd(2'd2, v); chk("R3 guard reset", {24'd0, v}, 32'h00);
        chk("R6 pmode single", {30'd0, pmode_o}, 32'd0);
        ext_rst_n = 1'b1;
        vec_seq("R8 vectors 16-bit", 1'b0);

        // R3 / R8: microprocessor start, 8-bit bus
        mode_pin = 1'b1; bus8_sel = 1'b1;
        hw_reset(24);
        rd(2'd0, v); chk("R3 cfg0 reset micro", {24'd0, v}, 32'h03);
        chk("R6 pmode micro", {30'd0, pmode_o}, 32'd3);
        ext_rst_n = 1'b1;
        vec_seq("R8 vectors 8-bit", 1'b1);

        // R1: low-duration sweep around the 20-cycle threshold
        mode_pin = 1'b0; bus8_sel = 1'b0;
        for (int n = 15; n <= 23; n++) begin
            repeat (30) @(negedge clk);
            ext_rst_n = 1'b0;
            repeat (n) @(negedge clk);
            ext_rst_n = 1'b1;
            saw = 1'b0;
            for (int c = 0; c < 8; c++) begin
                if (rst_o) saw = 1'b1;
                @(negedge clk);
            end
            chk($sformatf("R1 low for %0d cycles", n), {31'd0, saw}, {31'd0, (n >= 20)});
        end
        repeat (10) @(negedge clk);

        // R5 / R9: locked writes ignored, address 3 inert
        wr(2'd0, 8'h41);
        wr(2'd1, 8'h37);
        wr(2'd3, 8'hFF);
        wr(2'd0, 8'h08);
        saw = 1'b0;
        for (int c = 0; c < 6; c++) begin
            if (rst_o) saw = 1'b1;
            @(negedge clk);
        end
        chk("R5 locked soft reset ignored", {31'd0, saw}, 32'd0);
        rd(2'd0, v); chk("R5 locked cfg0", {24'd0, v}, 32'h80);
        rd(2'd1, v); chk("R5 locked cfg1", {24'd0, v}, 32'h00);
        rd(2'd3, v); chk("R9 addr3 reads zero", {24'd0, v}, 32'h00);

        // R5: guard keeps only its unlock bit
        wr(2'd2, 8'hFF);
        rd(2'd2, v); chk("R5 guard readback", {24'd0, v}, 32'h02);

        // R7: exhaustive register-1 sweep
        for (int d = 0; d < 256; d++) begin
            wr(2'd1, 8'(d));
            rd(2'd1, v);
            chk($sformatf("R7 cfg1 %02h", d),
                {19'd0, v, area_o, mem_wait_o, strobe_sel_o},
                {19'd0, 8'(d) & 8'h37, 2'(d), 1'(d >> 2), 2'(d >> 4)});
        end

        // R6: mode field sweep with forbidden code
        prev_mode = 2'b00;
        foreach (v[i]) begin end
        for (int s = 0; s < 6; s++) begin
            logic [1:0] m;
            m = (s == 0) ? 2'd1 : (s == 1) ? 2'd2 : (s == 2) ? 2'd3 :
                (s == 3) ? 2'd2 : (s == 4) ? 2'd0 : 2'd2;
            wr(2'd0, {6'b010000, m});
            exp_mode = (m == 2'b10) ? prev_mode : m;
            rd(2'd0, v);
            chk($sformatf("R6 mode write %0d", m), {22'd0, v, pmode_o},
                {22'd0, 6'b010000, exp_mode, exp_mode});
            prev_mode = exp_mode;
        end

        // R4: software reset restores defaults for the new start mode
        wr(2'd1, 8'h15);
        mode_pin = 1'b1; bus8_sel = 1'b1;
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h08;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R4 soft reset asserted", {31'd0, rst_o}, 32'd1);
        repeat (3) @(negedge clk);
        chk("R4 soft reset still asserted", {31'd0, rst_o}, 32'd1);
        vec_seq("R8 vectors after soft reset", 1'b1);
        rd(2'd0, v); chk("R4 cfg0 after soft reset (bit 3 clear)", {24'd0, v}, 32'h03);
        rd(2'd1, v); chk("R4 cfg1 after soft reset", {24'd0, v}, 32'h00);
        rd(2'd2, v); chk("R4 guard after soft reset", {24'd0, v}, 32'h00);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule